// File: doc/BRIEF.md
# DMA Staging Byte Buffer

This block is a four-byte staging store placed between a peripheral-side bus, where byte-wide DMA slave devices live, and a 32-bit system bus. Batching DMA bytes into words cuts the number of system-bus transactions a DMA transfer needs.

The block works in one of two directions. In read direction, the system side fills it one byte per beat with data fetched from memory, and the peripheral drains those bytes in arrival order. In write direction, the peripheral pushes bytes into lanes 0 to 3. The buffer then hands a 32-bit word and a lane mask to the system side as a flush request. The flush ends when the system side returns a done pulse.

A falling DMA acknowledge line marks a change of peripheral-bus owner. In read direction this discards whatever is held. In write direction it forces a flush, even when only some lanes are filled. From the moment a flush is scheduled until it completes, reads from other system masters aimed at this bridge are answered with retry. Writes from those masters are always let through, so the two sides cannot livelock.

Top module: `dma_stage_buf`

## Requirements
- R1: The store holds at most four bytes. In write direction a fifth byte cycle is stalled (per_stall_o high). In read direction sys_fill_ready_o is low once four bytes are held.
- R2: In read direction, when any bit of chan_ack_i goes from 1 to 0, all held bytes are discarded and the buffer is empty from the next cycle. In that same cycle sys_fill_ready_o is low and per_stall_o is high, and no flush request is raised.
- R3: In write direction, sys_flush_req_o rises in the cycle after the fourth byte is taken. sys_flush_data_o carries the first byte in bits [7:0], the second in [15:8], the third in [23:16] and the fourth in [31:24].
- R4: In write direction with one to three bytes held, a 1-to-0 change on any chan_ack_i bit raises sys_flush_req_o in the next cycle. With no bytes held, such a change raises no flush.
- R5: per_stall_o is high from the cycle a flush is scheduled until the cycle after sys_flush_done_i is sampled high with sys_flush_req_o high. sys_flush_req_o falls in that same cycle. sys_flush_done_i has no effect while no flush is pending.
- R6: While a flush is scheduled or pending, sys_retry_o is high in any cycle where sys_cmd_valid_i=1 and sys_cmd_rd_i=1. It is low whenever sys_cmd_valid_i=0.
- R7: sys_retry_o is never high for a write command (sys_cmd_rd_i=0), including while a flush is pending.
- R8: sys_flush_be_o bit i is 1 exactly when lane i holds a byte. A flush of n bytes gives the mask (1<<n)-1.
- R9: In read direction, after sys_fill_ready_o goes low because the store is full, it returns high in the cycle after the peripheral drains one byte.
- R10: The direction is sampled from dir_wr_i (1 = write, 0 = read) while the store is empty and no flush is pending. While any byte is held, changes on dir_wr_i have no effect.
- R11: In read direction, per_rdata_o shows the oldest held byte, and bytes leave in the order they were filled.
- R12: After reset, the store is empty, no flush is pending, sys_retry_o is low, and sys_flush_be_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_ack_i | input | NUM_CH | Per-channel DMA acknowledge, 1 = active |
| dir_wr_i | input | 1 | Transfer direction, 1 = peripheral to system |
| per_req_i | input | 1 | Peripheral byte cycle request |
| per_wdata_i | input | BYTE_W | Byte pushed in write direction |
| per_rdata_o | output | BYTE_W | Oldest held byte in read direction |
| per_stall_o | output | 1 | Byte cycle must wait |
| sys_fill_valid_i | input | 1 | System-side fill byte valid |
| sys_fill_data_i | input | BYTE_W | System-side fill byte |
| sys_fill_ready_o | output | 1 | Fill byte can be taken |
| sys_flush_req_o | output | 1 | Flush word pending |
| sys_flush_data_o | output | NUM_BYTES*BYTE_W | Flush word, lane 0 in the low byte |
| sys_flush_be_o | output | NUM_BYTES | Valid-lane mask of the flush word |
| sys_flush_done_i | input | 1 | Flush completed |
| sys_cmd_valid_i | input | 1 | Other system master targets this bridge |
| sys_cmd_rd_i | input | 1 | That command is a read |
| sys_retry_o | output | 1 | Retry the current command |

## Verification
The bench builds the block with NUM_BYTES=4 and BYTE_W=8, which gives the full 32-bit flush word and all four lane masks. It sets NUM_CH=2, so that a flush or discard can be triggered by a drop on either acknowledge line while the other line stays high. These values also bring several boundaries within reach: a full-word flush, a two-lane partial flush, an ownership drop on an empty store, and a full store in read direction with a direction change attempted while bytes are held.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
  typedef enum logic {
    MODE_RD = 1'b0,
    MODE_WR = 1'b1
  } dsb_mode_e;
endpackage

// File: rtl/dsb_ack_fall.sv
module dsb_ack_fall #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ack_i,
  output logic         fall_o
);
  logic [W-1:0] ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= '0;
    else         ack_q <= ack_i;
  end

  assign fall_o = |(ack_q & ~ack_i);
endmodule

// File: rtl/dsb_store.sv
module dsb_store #(
  parameter int unsigned NB = 4,
  parameter int unsigned DW = 8,
  localparam int unsigned IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [IW-1:0]  widx_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [IW-1:0]  ridx_i,
  output logic [DW-1:0]  rdata_o,
  output logic [NB*DW-1:0] flat_o
);
  logic [DW-1:0] lane_q [NB];

  for (genvar i = 0; i < NB; i++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          lane_q[i] <= '0;
      else if (we_i && widx_i == IW'(i))    lane_q[i] <= wdata_i;
    end
    assign flat_o[i*DW +: DW] = lane_q[i];
  end

  assign rdata_o = lane_q[ridx_i];
endmodule

// File: rtl/dsb_ctrl.sv
module dsb_ctrl
  import dsb_pkg::*;
#(
  parameter int unsigned NB = 4,
  localparam int unsigned IW = (NB > 1) ? $clog2(NB) : 1,
  localparam int unsigned CW = $clog2(NB + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dir_wr_i,
  input  logic          ack_fall_i,
  input  logic          per_req_i,
  input  logic          fill_valid_i,
  input  logic          flush_done_i,
  input  logic          cmd_valid_i,
  input  logic          cmd_rd_i,
  output logic          per_stall_o,
  output logic          fill_ready_o,
  output logic          we_o,
  output logic          wsel_per_o,
  output logic [IW-1:0] widx_o,
  output logic [IW-1:0] ridx_o,
  output logic          flush_req_o,
  output logic [NB-1:0] flush_be_o,
  output logic          retry_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] rd_ptr_q, rd_ptr_d;
  logic          pend_q, pend_d;
  dsb_mode_e     mode_q, mode_eff;
  logic          empty, full, is_wr, start_flush;
  logic          per_go, push, pop, fill;
  logic [CW-1:0] wsum;

  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CW'(NB));
  // direction is free only when nothing is held
  assign mode_eff = (empty && !pend_q) ? dsb_mode_e'(dir_wr_i) : mode_q;
  assign is_wr    = (mode_eff == MODE_WR);

  assign start_flush = is_wr && !empty && !pend_q && (full || ack_fall_i);

  assign per_stall_o  = pend_q | start_flush | ack_fall_i | (is_wr ? full : empty);
  assign fill_ready_o = !is_wr && !full && !ack_fall_i && !pend_q;

  assign per_go = per_req_i & ~per_stall_o;
  assign push   = per_go & is_wr;
  assign pop    = per_go & ~is_wr;
  assign fill   = fill_valid_i & fill_ready_o;

  assign wsum       = CW'(rd_ptr_q) + cnt_q;
  assign we_o       = push | fill;
  assign wsel_per_o = is_wr;
  assign widx_o     = wsum[IW-1:0];
  assign ridx_o     = rd_ptr_q;

  assign flush_req_o = pend_q;
  assign retry_o     = cmd_valid_i & cmd_rd_i & (pend_q | start_flush);

  for (genvar i = 0; i < NB; i++) begin : g_be
    assign flush_be_o[i] = (CW'(i) < cnt_q);
  end

  always_comb begin
    cnt_d    = cnt_q;
    rd_ptr_d = rd_ptr_q;
    pend_d   = pend_q;
    if (pend_q) begin
      if (flush_done_i) begin
        cnt_d    = '0;
        rd_ptr_d = '0;
        pend_d   = 1'b0;
      end
    end else if (start_flush) begin
      pend_d = 1'b1;
    end else if (ack_fall_i && !is_wr) begin
      cnt_d    = '0;
      rd_ptr_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(push | fill) - CW'(pop);
      if (pop) rd_ptr_d = rd_ptr_q + IW'(1);
      if (cnt_d == '0) rd_ptr_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      rd_ptr_q <= '0;
      pend_q   <= 1'b0;
      mode_q   <= MODE_RD;
    end else begin
      cnt_q    <= cnt_d;
      rd_ptr_q <= rd_ptr_d;
      pend_q   <= pend_d;
      mode_q   <= mode_eff;
    end
  end

  // R1
  cap_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(NB));

  // R2
  rd_discard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_fall_i && mode_q == MODE_RD && !empty) |=> (cnt_q == '0 && !pend_q));

  // R3
  full_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_WR && full && !pend_q) |=> pend_q);

  // R5
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !flush_done_i) |=> (pend_q && $stable(cnt_q)));

  // R5
  pend_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && flush_done_i) |=> (!pend_q && cnt_q == '0));

  // R10
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !empty |=> $stable(mode_q));
endmodule

// File: rtl/dma_stage_buf.sv
module dma_stage_buf #(
  parameter int unsigned NUM_BYTES = 4,
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned NUM_CH    = 4,
  localparam int unsigned IW = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
  localparam int unsigned WW = NUM_BYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] chan_ack_i,
  input  logic              dir_wr_i,
  input  logic              per_req_i,
  input  logic [BYTE_W-1:0] per_wdata_i,
  output logic [BYTE_W-1:0] per_rdata_o,
  output logic              per_stall_o,
  input  logic              sys_fill_valid_i,
  input  logic [BYTE_W-1:0] sys_fill_data_i,
  output logic              sys_fill_ready_o,
  output logic              sys_flush_req_o,
  output logic [WW-1:0]     sys_flush_data_o,
  output logic [NUM_BYTES-1:0] sys_flush_be_o,
  input  logic              sys_flush_done_i,
  input  logic              sys_cmd_valid_i,
  input  logic              sys_cmd_rd_i,
  output logic              sys_retry_o
);
  logic              ack_fall;
  logic              we, wsel_per;
  logic [IW-1:0]     widx, ridx;
  logic [BYTE_W-1:0] wdata;

  dsb_ack_fall #(.W(NUM_CH)) u_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ack_i  (chan_ack_i),
    .fall_o (ack_fall)
  );

  dsb_ctrl #(.NB(NUM_BYTES)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dir_wr_i     (dir_wr_i),
    .ack_fall_i   (ack_fall),
    .per_req_i    (per_req_i),
    .fill_valid_i (sys_fill_valid_i),
    .flush_done_i (sys_flush_done_i),
    .cmd_valid_i  (sys_cmd_valid_i),
    .cmd_rd_i     (sys_cmd_rd_i),
    .per_stall_o  (per_stall_o),
    .fill_ready_o (sys_fill_ready_o),
    .we_o         (we),
    .wsel_per_o   (wsel_per),
    .widx_o       (widx),
    .ridx_o       (ridx),
    .flush_req_o  (sys_flush_req_o),
    .flush_be_o   (sys_flush_be_o),
    .retry_o      (sys_retry_o)
  );

  assign wdata = wsel_per ? per_wdata_i : sys_fill_data_i;

  dsb_store #(.NB(NUM_BYTES), .DW(BYTE_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .widx_i  (widx),
    .wdata_i (wdata),
    .ridx_i  (ridx),
    .rdata_o (per_rdata_o),
    .flat_o  (sys_flush_data_o)
  );

  // R7
  wr_no_retry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_cmd_valid_i && !sys_cmd_rd_i && sys_flush_req_o) |-> !sys_retry_o);

  // R8
  be_dense_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_flush_req_o |-> (sys_flush_be_o != '0 && ((sys_flush_be_o + 1'b1) & sys_flush_be_o) == '0));
endmodule

// File: tb/dma_stage_buf_tb.sv
module dma_stage_buf_tb;
  localparam int CLK_P = 10;
  localparam int NB = 4;
  localparam int DW = 8;
  localparam int NCH = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] ack = '0;
  logic dir_wr = 1'b0;
  logic per_req = 1'b0;
  logic [DW-1:0] per_wdata = '0;
  logic [DW-1:0] per_rdata;
  logic per_stall;
  logic fill_valid = 1'b0;
  logic [DW-1:0] fill_data = '0;
  logic fill_ready;
  logic flush_req;
  logic [NB*DW-1:0] flush_data;
  logic [NB-1:0] flush_be;
  logic flush_done = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_rd = 1'b0;
  logic retry;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dma_stage_buf #(.NUM_BYTES(NB), .BYTE_W(DW), .NUM_CH(NCH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .chan_ack_i(ack), .dir_wr_i(dir_wr),
    .per_req_i(per_req), .per_wdata_i(per_wdata), .per_rdata_o(per_rdata),
    .per_stall_o(per_stall), .sys_fill_valid_i(fill_valid),
    .sys_fill_data_i(fill_data), .sys_fill_ready_o(fill_ready),
    .sys_flush_req_o(flush_req), .sys_flush_data_o(flush_data),
    .sys_flush_be_o(flush_be), .sys_flush_done_i(flush_done),
    .sys_cmd_valid_i(cmd_valid), .sys_cmd_rd_i(cmd_rd), .sys_retry_o(retry)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(logic [7:0] b);
    @(negedge clk); per_req = 1'b1; per_wdata = b;
    @(negedge clk); per_req = 1'b0;
  endtask

  task automatic fill(logic [7:0] b);
    @(negedge clk); fill_valid = 1'b1; fill_data = b;
    @(negedge clk); fill_valid = 1'b0;
  endtask

  task automatic pop_exp(logic [7:0] b, string req);
    @(negedge clk); per_req = 1'b1;
    #1 chk(req, 32'(per_rdata), 32'(b));
    @(negedge clk); per_req = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk); flush_done = 1'b1;
    @(negedge clk); flush_done = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk("R12 flush_req", 32'(flush_req), 0);
    chk("R12 be", 32'(flush_be), 0);
    cmd_valid = 1'b1; cmd_rd = 1'b1; #1;
    chk("R12 retry", 32'(retry), 0);
    cmd_valid = 1'b0;
    chk("R12 fill_ready", 32'(fill_ready), 1);
  endtask

  task automatic t_write_full();
    dir_wr = 1'b1; ack = 2'b01;
    push(8'h11); push(8'h22); push(8'h33); push(8'h44);
    // fourth byte taken; flush scheduled this cycle
    cmd_valid = 1'b1; cmd_rd = 1'b1; #1;
    chk("R1 stall at full", 32'(per_stall), 1);
    chk("R6 retry when scheduled", 32'(retry), 1);
    chk("R3 no req yet", 32'(flush_req), 0);
    @(negedge clk);
    chk("R3 flush_req", 32'(flush_req), 1);
    chk("R3 data", flush_data, 32'h44332211);
    chk("R8 be full", 32'(flush_be), 32'hf);
    chk("R6 retry pending", 32'(retry), 1);
    cmd_rd = 1'b0; #1;
    chk("R7 write not retried", 32'(retry), 0);
    cmd_valid = 1'b0; #1;
    chk("R6 idle no retry", 32'(retry), 0);
    per_req = 1'b1; per_wdata = 8'h99; #1;
    chk("R5 stall while pending", 32'(per_stall), 1);
    @(negedge clk);
    per_req = 1'b0;
    chk("R5 still pending", 32'(flush_req), 1);
    done_pulse();
    chk("R5 req cleared", 32'(flush_req), 0);
    chk("R5 stall cleared", 32'(per_stall), 0);
    chk("R5 be empty", 32'(flush_be), 0);
  endtask

  task automatic t_write_partial();
    dir_wr = 1'b1; ack = 2'b11;
    @(negedge clk);
    push(8'haa); push(8'hbb);
    ack = 2'b01; cmd_valid = 1'b1; cmd_rd = 1'b1; #1;
    chk("R4 stall on drop", 32'(per_stall), 1);
    chk("R6 retry on drop", 32'(retry), 1);
    cmd_valid = 1'b0;
    @(negedge clk);
    chk("R4 partial flush_req", 32'(flush_req), 1);
    chk("R8 be two lanes", 32'(flush_be), 32'h3);
    chk("R4 partial data", 32'(flush_data[15:0]), 32'hbbaa);
    ack = 2'b11;
    done_pulse();
    chk("R4 partial done", 32'(flush_req), 0);
    // drop on empty store: no flush
    ack = 2'b10;
    @(negedge clk);
    @(negedge clk);
    chk("R4 empty drop no flush", 32'(flush_req), 0);
    ack = 2'b11;
    // done with nothing pending is ignored
    done_pulse();
    push(8'h5a);
    chk("R5 stray done ignored", 32'(flush_be), 32'h1);
    ack = 2'b01;
    @(negedge clk);
    chk("R8 single lane", 32'(flush_be), 32'h1);
    chk("R4 single flush", 32'(flush_req), 1);
    done_pulse();
  endtask

  task automatic t_read();
    dir_wr = 1'b0; ack = 2'b01;
    @(negedge clk);
    fill(8'h05); fill(8'h06); fill(8'h07); fill(8'h08);
    #1 chk("R1 fill ready low at four", 32'(fill_ready), 0);
    dir_wr = 1'b1; #1;
    chk("R10 dir ignored stall", 32'(per_stall), 0);
    pop_exp(8'h05, "R11 oldest first");
    chk("R9 ready after drain", 32'(fill_ready), 1);
    chk("R10 still read mode", 32'(flush_req), 0);
    pop_exp(8'h06, "R11 second byte");
    fill(8'h09);
    pop_exp(8'h07, "R11 third byte");
    pop_exp(8'h08, "R11 fourth byte");
    pop_exp(8'h09, "R11 wrap byte");
    dir_wr = 1'b0;
  endtask

  task automatic t_read_discard();
    dir_wr = 1'b0; ack = 2'b11;
    @(negedge clk);
    fill(8'hc1); fill(8'hc2); fill(8'hc3);
    ack = 2'b10; #1;
    chk("R2 fill blocked on drop", 32'(fill_ready), 0);
    chk("R2 stall on drop", 32'(per_stall), 1);
    @(negedge clk);
    chk("R2 emptied", 32'(per_stall), 1);
    chk("R2 no flush", 32'(flush_req), 0);
    ack = 2'b11;
    fill(8'he7);
    pop_exp(8'he7, "R2 old bytes gone");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_full();
    t_write_partial();
    t_read();
    t_read_discard();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule